// File: doc/BRIEF.md
# Eight-Bit I/O Port with Peripheral Direction Override

This block is one general-purpose I/O port of eight pins. Firmware reaches it through a small register bus. Behind that bus sit three pieces of state: an output latch, a direction register (1 means input) and a two-stage synchroniser that samples the pins. The pads see one output value bit and one output-enable bit per pin. Firmware emulates an open-drain line by keeping the pin's latch bit at 0 and toggling its direction bit. Clearing the direction bit pulls the line low. Setting it lets the line float high.

Reading the data address returns the sampled pin levels. A separate address returns the latch exactly as it was written. A single-bit command sets or clears one latch bit and leaves the other seven alone, so firmware never needs a read-modify-write. This closes the usual trap in which sampled pin levels get copied back into the latch. A neighbouring peripheral, such as a serial bus engine driving an acknowledge, can take over the direction of chosen pins. That override lives only on the pad side. It is never stored in the firmware direction register, so a later firmware write cannot freeze a line low.

The port has no state machine. The only sequencing in it is the pin synchroniser's fixed two-edge delay.

Register addresses, decoded from `bus_addr`:
- 0: pin state. A read returns the synchronised pins. A write loads the latch.
- 1: latch. A read returns the latch. A write loads the latch.
- 2: direction. Read and write.
- 3: single-bit command. Write only. A read returns 0.

Top module: `gpio_port`

## Requirements
- R1: During and after reset, before any write, the latch reads 0x00, the direction register reads 0xFF, and `pad_oe` and `pad_out` are 0x00.
- R2: A write to address 0 or address 1 loads `bus_wdata` into the latch. From the clock edge that performs the write, `pad_out` equals the latch on every pin that has no override.
- R3: A read of address 0 returns `pad_in` as sampled two rising edges earlier. After only one edge, the read still returns the old level. The latch contents never appear at address 0.
- R4: A read of address 1 returns the latch, whatever the pin levels are.
- R5: Address 2 reads back the last value written to it. On a pin with no override, `pad_oe` equals the inverse of that direction bit. With the latch bit at 0, this gives an open-drain low when the bit is 0 and a released line when the bit is 1.
- R6: A write to address 3 takes the pin index from `bus_wdata[2:0]` and the new value from `bus_wdata[3]`. It changes exactly that one latch bit. `bus_wdata[7:4]` is ignored. A read of address 3 returns 0x00.
- R7: While `ovr_en[i]` is 1, `pad_oe[i]` equals `ovr_oe[i]` and `pad_out[i]` is 0, whatever the direction bit and the latch bit are.
- R8: An override never changes the direction register. A direction write made during an override is stored and read back unaltered. When the override is released, `pad_oe` returns to the inverse of the stored direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Raw pin levels |
| pad_out | output | 8 | Pin output value |
| pad_oe | output | 8 | Pin output enable (1 = drive) |
| ovr_en | input | 8 | Peripheral override active, per pin |
| ovr_oe | input | 8 | Peripheral output enable used while overriding |

## Verification
The latch path is tried with a short sequence of mixed work:
- whole-byte writes through both data addresses;
- single-bit sets and clears at both edge indices and at a middle index;
- one command whose upper data bits are set.

Each step is checked against a latch value worked out in advance. This separates a correct single-bit update from one that touches a neighbour bit or decodes the index wrongly.

Pin reads use a level that differs from the latch. This tells a true pin sample apart from a latch echo, and the same level is checked after one edge and after two, which pins down the synchroniser depth.

Override checks mix enabled and disabled override bits with a direction write made during the override. This separates the pad-side mux from any leak of the override into the stored direction.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [1:0] {
        ADR_PINS  = 2'd0,
        ADR_LATCH = 2'd1,
        ADR_DIR   = 2'd2,
        ADR_BITOP = 2'd3
    } gpio_addr_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  gpio_addr_e       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] latch_q,
    output logic [WIDTH-1:0] dir_q
);

    logic [IDX_W-1:0] bit_idx;
    logic             bit_val;
    logic [WIDTH-1:0] latch_d;

    assign bit_idx = wdata[IDX_W-1:0];
    assign bit_val = wdata[IDX_W];

    always_comb begin
        latch_d = latch_q;
        if (we) begin
            unique case (addr)
                ADR_PINS, ADR_LATCH: latch_d = wdata;
                ADR_BITOP: begin
                    for (int i = 0; i < WIDTH; i++) begin
                        if (bit_idx == IDX_W'(i)) latch_d[i] = bit_val;
                    end
                end
                default: latch_d = latch_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '1;
        end else begin
            latch_q <= latch_d;
            if (we && addr == ADR_DIR) dir_q <= wdata;
        end
    end

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |=> (latch_q == '0 && dir_q == '1)); // R1

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr != ADR_DIR) |=> $stable(latch_q)); // R2

    AST_BITOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADR_BITOP) |=> $countones(latch_q ^ $past(latch_q)) <= 1); // R6

    AST_DIR_ONLY_FIRMWARE: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && addr == ADR_DIR) |=> $stable(dir_q)); // R8

endmodule

// File: rtl/gpio_drive.sv
module gpio_drive #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] ovr_en,
    input  logic [WIDTH-1:0] ovr_oe,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            assign pad_oe[b]  = ovr_en[b] ? ovr_oe[b] : ~dir_q[b];
            assign pad_out[b] = ovr_en[b] ? 1'b0      : latch_q[b];
        end
    endgenerate

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [1:0]       bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] ovr_en,
    input  logic [WIDTH-1:0] ovr_oe
);

    gpio_addr_e       addr_e;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pins_s;

    assign addr_e = gpio_addr_e'(bus_addr);

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (pad_in),
        .d_out (pins_s)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (bus_we),
        .addr    (addr_e),
        .wdata   (bus_wdata),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    gpio_drive #(.WIDTH(WIDTH)) u_drive (
        .latch_q (latch_q),
        .dir_q   (dir_q),
        .ovr_en  (ovr_en),
        .ovr_oe  (ovr_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    always_comb begin
        unique case (addr_e)
            ADR_PINS:  bus_rdata = pins_s;
            ADR_LATCH: bus_rdata = latch_q;
            ADR_DIR:   bus_rdata = dir_q;
            default:   bus_rdata = '0;
        endcase
    end

    AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ovr_en) & (pad_oe ^ ~dir_q)) == '0); // R5

    AST_OVR_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovr_en & pad_out) == '0) && ((ovr_en & (pad_oe ^ ovr_oe)) == '0)); // R7

    AST_OUT_FROM_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ovr_en) & (pad_out ^ latch_q)) == '0); // R2

endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       bus_we;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in;
    logic [7:0] pad_out;
    logic [7:0] pad_oe;
    logic [7:0] ovr_en;
    logic [7:0] ovr_oe;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .ovr_en    (ovr_en),
        .ovr_oe    (ovr_oe)
    );

    // {addr, wdata, expected latch afterwards}
    localparam logic [17:0] VEC [8] = '{
        {2'd0, 8'hA5, 8'hA5},
        {2'd3, 8'h09, 8'hA7},
        {2'd3, 8'h07, 8'h27},
        {2'd3, 8'h0F, 8'hA7},
        {2'd1, 8'h3C, 8'h3C},
        {2'd3, 8'h02, 8'h38},
        {2'd3, 8'h08, 8'h39},
        {2'd3, 8'hF3, 8'h31}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
        pad_in = 8'h00; ovr_en = 8'h00; ovr_oe = 8'h00;
        repeat (3) @(negedge clk);
        rd(2'd1, r); chk("R1 latch", r, 8'h00);
        rd(2'd2, r); chk("R1 dir", r, 8'hFF);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // main table: R2 whole writes, R6 single-bit commands
        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][17:16], VEC[i][15:8]);
            rd(2'd1, r);
            chk((VEC[i][17:16] == 2'd3) ? "R6 latch" : "R2/R4 latch", r, VEC[i][7:0]);
            chk("R2 pad_out", pad_out, VEC[i][7:0]);
        end

        rd(2'd3, r); chk("R6 bitop reads zero", r, 8'h00);

        // R3 synchroniser depth, pins differ from latch 0x31
        @(negedge clk); pad_in = 8'h5A;
        @(negedge clk);
        rd(2'd0, r); chk("R3 one edge old", r, 8'h00);
        @(negedge clk);
        rd(2'd0, r); chk("R3 two edges", r, 8'h5A);
        rd(2'd1, r); chk("R4 latch independent of pins", r, 8'h31);

        // R5 direction
        wr(2'd2, 8'h0F);
        rd(2'd2, r); chk("R5 dir readback", r, 8'h0F);
        chk("R5 pad_oe", pad_oe, 8'hF0);

        // R7 override, R8 direction untouched
        ovr_en = 8'h03; ovr_oe = 8'h01;
        #1;
        chk("R7 pad_oe", pad_oe, 8'hF1);
        chk("R7 pad_out low", pad_out, 8'h30);
        wr(2'd2, 8'hFE);
        rd(2'd2, r); chk("R8 dir during override", r, 8'hFE);
        chk("R7 pad_oe after dir write", pad_oe, 8'h01);
        ovr_en = 8'h00;
        #1;
        chk("R8 release restores oe", pad_oe, 8'h01);
        chk("R8 release restores out", pad_out, 8'h31);

        // R5 open-drain emulation with latch 0
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h00);
        chk("R5 open-drain driven", pad_oe, 8'hFF);
        chk("R5 open-drain low", pad_out, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule